// File: doc/BRIEF.md
# Fixed-Priority Shared-Bus Arbiter with Lock

This block lets several bus masters share one slave path. Each master raises its cycle signal to ask for the bus. The arbiter grants the bus to exactly one requester, by fixed priority. It passes that master's address, write data, byte selects, write enable and strobe to the slave. The slave's acknowledge, error and retry come back only to the master that holds the grant, and read data goes to every master at once.

A master that holds the grant can keep it against a higher-priority requester in two ways. It can assert its lock input together with its cycle signal. It also keeps the bus while a strobed transfer waits for its termination. Outside those two cases, the grant is decided again on every clock edge.

The grant follows the cycle signal directly. When the owner drops its cycle signal, the grant ends in that same cycle. A new owner takes over at the next rising edge.

Top module: `wb_prio_arb`

## Requirements
- R1: While rst_ni is low, and on the first cycle after reset is released, grant_o is all zero and s_cyc_o is low, whatever the masters drive.
- R2: grant_o is one-hot or zero. Bit i is never set while m_cyc_i[i] is low, so the grant drops in the same cycle that the owner negates its cycle signal.
- R3: With no held owner, at each rising edge the grant moves to the lowest-indexed master whose m_cyc_i bit is high. Master 0 has the highest priority. If no master requests, the grant goes to zero.
- R4: s_cyc_o is high exactly when some grant_o bit is set. s_stb_o equals the granted master's strobe, so an owner that holds its cycle signal with its strobe low produces s_cyc_o=1 and s_stb_o=0.
- R5: s_adr_o, s_dat_o, s_sel_o and s_we_o equal the granted master's fields. Master i's fields are packed at bits [i*W +: W] of the flattened input buses.
- R6: m_ack_o[i], m_err_o[i] and m_rty_o[i] follow s_ack_i, s_err_i and s_rty_i only while grant_o[i], m_cyc_i[i] and m_stb_i[i] are all high. Otherwise they are low.
- R7: While the owner drives both its cycle signal and its lock input high, the grant does not move, even when a higher-priority master requests.
- R8: An owner that is unlocked and has its strobe low loses the grant at the next edge to a higher-priority requester.
- R9: While the owner's strobe is high and no termination has arrived, the grant holds. It is re-arbitrated at the edge that ends the cycle in which a termination is seen.
- R10: A lock input counts only while the same master's cycle signal is high. An owner that drops its cycle signal with lock still high releases the bus.
- R11: With no grant, s_cyc_o, s_stb_o and all termination outputs to the masters are low.
- R12: m_dat_o equals s_dat_i at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_cyc_i | input | N_MST | Bus request (cycle signal) per master |
| m_stb_i | input | N_MST | Transfer-valid strobe per master |
| m_we_i | input | N_MST | Write enable per master |
| m_lock_i | input | N_MST | Lock request per master |
| m_adr_i | input | N_MST*AW | Packed addresses |
| m_dat_i | input | N_MST*DW | Packed write data |
| m_sel_i | input | N_MST*DW/8 | Packed byte selects |
| m_dat_o | output | DW | Read data to all masters |
| m_ack_o | output | N_MST | Acknowledge per master |
| m_err_o | output | N_MST | Error per master |
| m_rty_o | output | N_MST | Retry per master |
| grant_o | output | N_MST | One-hot grant |
| s_cyc_o | output | 1 | Cycle signal to the slave |
| s_stb_o | output | 1 | Strobe to the slave |
| s_we_o | output | 1 | Write enable to the slave |
| s_adr_o | output | AW | Address to the slave |
| s_dat_o | output | DW | Write data to the slave |
| s_sel_o | output | DW/8 | Byte selects to the slave |
| s_ack_i | input | 1 | Slave acknowledge |
| s_err_i | input | 1 | Slave error |
| s_rty_i | input | 1 | Slave retry |
| s_dat_i | input | DW | Slave read data |

## Verification
The only state is the stored grant, and every output is decoded from it. A wrong grant therefore shows at the ports in the first cycle after the faulty edge. It appears as a mismatch on grant_o, as the wrong master's fields on the slave side, or as a termination delivered to the wrong master. The hold rules are the subtle part: lock, a pending strobe, and lock being ignored once the cycle signal drops. A hold-rule fault shows as the grant moving, or failing to move, at one specific edge. The bench therefore keeps its own grant model and compares it with the outputs after every edge, in directed sequences and under random traffic.

// File: rtl/wb_arb_pkg.sv
package wb_arb_pkg;
  typedef struct packed {
    logic ack;
    logic err;
    logic rty;
  } wb_term_t;
endpackage

// File: rtl/wb_arb_core.sv
module wb_arb_core #(
  parameter int N_MST = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MST-1:0] cyc_i,
  input  logic [N_MST-1:0] stb_i,
  input  logic [N_MST-1:0] lock_i,
  input  logic             term_i,
  output logic [N_MST-1:0] grant_o
);
  logic [N_MST-1:0] gnt_q, gnt_d, pick, eff;
  logic hold;

  assign eff = gnt_q & cyc_i;
  // lock and pending strobe only count while the owner still requests
  assign hold = (|(eff & lock_i)) | ((|(eff & stb_i)) & ~term_i);

  always_comb begin
    pick = '0;
    for (int i = N_MST-1; i >= 0; i--) begin
      if (cyc_i[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  assign gnt_d = hold ? gnt_q : pick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_q <= '0;
    else         gnt_q <= gnt_d;
  end

  assign grant_o = eff;
endmodule

// File: rtl/wb_arb_mux.sv
module wb_arb_mux
  import wb_arb_pkg::*;
#(
  parameter int N_MST = 3,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int SW   = DW/8
) (
  input  logic [N_MST-1:0]    grant_i,
  input  logic [N_MST-1:0]    stb_i,
  input  logic [N_MST-1:0]    we_i,
  input  logic [N_MST*AW-1:0] adr_i,
  input  logic [N_MST*DW-1:0] dat_i,
  input  logic [N_MST*SW-1:0] sel_i,
  input  wb_term_t            s_term_i,
  output logic                s_cyc_o,
  output logic                s_stb_o,
  output logic                s_we_o,
  output logic [AW-1:0]       s_adr_o,
  output logic [DW-1:0]       s_dat_o,
  output logic [SW-1:0]       s_sel_o,
  output logic [N_MST-1:0]    ack_o,
  output logic [N_MST-1:0]    err_o,
  output logic [N_MST-1:0]    rty_o
);
  assign s_cyc_o = |grant_i;
  assign s_stb_o = |(grant_i & stb_i);
  assign s_we_o  = |(grant_i & we_i);

  always_comb begin
    s_adr_o = '0;
    s_dat_o = '0;
    s_sel_o = '0;
    for (int i = 0; i < N_MST; i++) begin
      s_adr_o |= adr_i[i*AW +: AW] & {AW{grant_i[i]}};
      s_dat_o |= dat_i[i*DW +: DW] & {DW{grant_i[i]}};
      s_sel_o |= sel_i[i*SW +: SW] & {SW{grant_i[i]}};
    end
  end

  for (genvar g = 0; g < N_MST; g++) begin : g_term
    logic live;
    assign live     = grant_i[g] & stb_i[g];
    assign ack_o[g] = live & s_term_i.ack;
    assign err_o[g] = live & s_term_i.err;
    assign rty_o[g] = live & s_term_i.rty;
  end
endmodule

// File: rtl/wb_prio_arb.sv
module wb_prio_arb
  import wb_arb_pkg::*;
#(
  parameter int N_MST = 3,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int SW   = DW/8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_MST-1:0]    m_cyc_i,
  input  logic [N_MST-1:0]    m_stb_i,
  input  logic [N_MST-1:0]    m_we_i,
  input  logic [N_MST-1:0]    m_lock_i,
  input  logic [N_MST*AW-1:0] m_adr_i,
  input  logic [N_MST*DW-1:0] m_dat_i,
  input  logic [N_MST*SW-1:0] m_sel_i,
  output logic [DW-1:0]       m_dat_o,
  output logic [N_MST-1:0]    m_ack_o,
  output logic [N_MST-1:0]    m_err_o,
  output logic [N_MST-1:0]    m_rty_o,
  output logic [N_MST-1:0]    grant_o,
  output logic                s_cyc_o,
  output logic                s_stb_o,
  output logic                s_we_o,
  output logic [AW-1:0]       s_adr_o,
  output logic [DW-1:0]       s_dat_o,
  output logic [SW-1:0]       s_sel_o,
  input  logic                s_ack_i,
  input  logic                s_err_i,
  input  logic                s_rty_i,
  input  logic [DW-1:0]       s_dat_i
);
  wb_term_t         s_term;
  logic [N_MST-1:0] gnt;

  assign s_term  = '{ack: s_ack_i, err: s_err_i, rty: s_rty_i};
  assign m_dat_o = s_dat_i;
  assign grant_o = gnt;

  wb_arb_core #(.N_MST(N_MST)) i_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cyc_i  (m_cyc_i),
    .stb_i  (m_stb_i),
    .lock_i (m_lock_i),
    .term_i (s_ack_i | s_err_i | s_rty_i),
    .grant_o(gnt)
  );

  wb_arb_mux #(.N_MST(N_MST), .AW(AW), .DW(DW)) i_mux (
    .grant_i (gnt),
    .stb_i   (m_stb_i),
    .we_i    (m_we_i),
    .adr_i   (m_adr_i),
    .dat_i   (m_dat_i),
    .sel_i   (m_sel_i),
    .s_term_i(s_term),
    .s_cyc_o (s_cyc_o),
    .s_stb_o (s_stb_o),
    .s_we_o  (s_we_o),
    .s_adr_o (s_adr_o),
    .s_dat_o (s_dat_o),
    .s_sel_o (s_sel_o),
    .ack_o   (m_ack_o),
    .err_o   (m_err_o),
    .rty_o   (m_rty_o)
  );
endmodule

// File: rtl/wb_prio_arb_chk.sv
module wb_prio_arb_chk #(
  parameter int N_MST = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MST-1:0] m_cyc_i,
  input logic [N_MST-1:0] m_stb_i,
  input logic [N_MST-1:0] m_lock_i,
  input logic [N_MST-1:0] m_ack_o,
  input logic [N_MST-1:0] m_err_o,
  input logic [N_MST-1:0] m_rty_o,
  input logic [N_MST-1:0] grant_o,
  input logic             s_cyc_o,
  input logic             s_stb_o,
  input logic             s_ack_i,
  input logic             s_err_i,
  input logic             s_rty_i
);
  logic [N_MST-1:0] term_any;
  assign term_any = m_ack_o | m_err_o | m_rty_o;

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && ((grant_o & ~m_cyc_i) == '0)); // R2

  AST_TERM_ROUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_any & ~(grant_o & m_cyc_i & m_stb_i)) == '0); // R6

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(grant_o & m_lock_i)) |=> (grant_o == $past(grant_o)) || !(|($past(grant_o) & m_cyc_i))); // R7

  AST_PENDING_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(grant_o & m_stb_i)) && !s_ack_i && !s_err_i && !s_rty_i)
    |=> (grant_o == $past(grant_o)) || !(|($past(grant_o) & m_cyc_i))); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o == '0) |-> (!s_cyc_o && !s_stb_o && term_any == '0)); // R11
endmodule

bind wb_prio_arb wb_prio_arb_chk #(.N_MST(N_MST)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .m_cyc_i (m_cyc_i),
  .m_stb_i (m_stb_i),
  .m_lock_i(m_lock_i),
  .m_ack_o (m_ack_o),
  .m_err_o (m_err_o),
  .m_rty_o (m_rty_o),
  .grant_o (grant_o),
  .s_cyc_o (s_cyc_o),
  .s_stb_o (s_stb_o),
  .s_ack_i (s_ack_i),
  .s_err_i (s_err_i),
  .s_rty_i (s_rty_i)
);

// File: tb/test_wb_prio_arb.sv
`timescale 1ns/1ps
module test_wb_prio_arb;
  localparam int N  = 3;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = DW/8;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] cyc = '0, stb = '0, we = '0, lock = '0;
  logic [N*AW-1:0] adr = '0;
  logic [N*DW-1:0] wdat = '0;
  logic [N*SW-1:0] sel = '0;
  logic s_ack = 0, s_err = 0, s_rty = 0;
  logic [DW-1:0] s_rdat = '0;
  logic [DW-1:0] m_dat;
  logic [N-1:0] ack, err, rty, gnt;
  logic s_cyc, s_stb, s_we;
  logic [AW-1:0] s_adr;
  logic [DW-1:0] s_dat;
  logic [SW-1:0] s_sel;

  int n_tests = 0, n_fail = 0;
  logic [N-1:0] mq = '0;

  always #4 clk = ~clk;

  wb_prio_arb #(.N_MST(N), .AW(AW), .DW(DW)) i_wb_prio_arb (
    .clk_i(clk), .rst_ni(rst_n),
    .m_cyc_i(cyc), .m_stb_i(stb), .m_we_i(we), .m_lock_i(lock),
    .m_adr_i(adr), .m_dat_i(wdat), .m_sel_i(sel),
    .m_dat_o(m_dat), .m_ack_o(ack), .m_err_o(err), .m_rty_o(rty),
    .grant_o(gnt), .s_cyc_o(s_cyc), .s_stb_o(s_stb), .s_we_o(s_we),
    .s_adr_o(s_adr), .s_dat_o(s_dat), .s_sel_o(s_sel),
    .s_ack_i(s_ack), .s_err_i(s_err), .s_rty_i(s_rty), .s_dat_i(s_rdat)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model_next(input logic [N-1:0] q);
    logic [N-1:0] e;
    logic [N-1:0] r;
    e = q & cyc;
    if ((|(e & lock)) || ((|(e & stb)) && !(s_ack | s_err | s_rty))) return q;
    r = '0;
    for (int i = 0; i < N; i++) if (cyc[i] && r == '0) r[i] = 1'b1;
    return r;
  endfunction

  task automatic check_all();
    logic [N-1:0] eg, live;
    logic [AW-1:0] ea;
    logic [DW-1:0] ed;
    logic [SW-1:0] es;
    logic ew;
    eg = mq & cyc;
    live = eg & stb;
    ea = '0; ed = '0; es = '0; ew = 0;
    for (int i = 0; i < N; i++) if (eg[i]) begin
      ea = adr[i*AW +: AW]; ed = wdat[i*DW +: DW]; es = sel[i*SW +: SW]; ew = we[i];
    end
    chk(gnt == eg, "R3 grant", gnt, eg);
    chk(s_cyc == (eg != '0) && s_stb == (live != '0), "R4 cyc/stb", {s_cyc, s_stb}, {eg != '0, live != '0});
    chk(s_adr == ea && s_dat == ed && s_sel == es && s_we == ew, "R5 mux",
        {s_adr, s_sel, s_we}, {ea, es, ew});
    chk(ack == (live & {N{s_ack}}) && err == (live & {N{s_err}}) && rty == (live & {N{s_rty}}),
        "R6 term", {ack, err, rty}, {live & {N{s_ack}}, live & {N{s_err}}, live & {N{s_rty}}});
    if (eg == '0)
      chk(!s_cyc && !s_stb && (ack | err | rty) == '0, "R11 idle", {s_cyc, s_stb, ack | err | rty}, '0);
    chk(m_dat == s_rdat, "R12 rdata", m_dat, s_rdat);
  endtask

  task automatic run();
    logic [N-1:0] nx;
    nx = model_next(mq);
    @(posedge clk);
    mq = nx;
    #1;
    check_all();
    @(negedge clk);
  endtask

  task automatic fields();
    for (int i = 0; i < N; i++) begin
      adr[i*AW +: AW] = $urandom;
      wdat[i*DW +: DW] = $urandom;
      sel[i*SW +: SW] = $urandom;
    end
    we = $urandom;
    s_rdat = $urandom;
  endtask

  initial begin
    #(8*200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    fields();
    cyc = '1; stb = '1; lock = '1;
    repeat (2) @(negedge clk);
    chk(gnt == '0 && !s_cyc, "R1 reset", {gnt, s_cyc}, '0);
    rst_n = 1;
    #1;
    chk(gnt == '0 && !s_cyc, "R1 after release", {gnt, s_cyc}, '0);
    cyc = '0; stb = '0; lock = '0;
    @(negedge clk);
    run();
    mq = '0;

    // R7: locked low-priority owner keeps the bus
    cyc = 3'b100; lock = 3'b100; stb = 3'b000; fields();
    run();
    chk(gnt == 3'b100, "R3 sole requester", gnt, 3'b100);
    cyc = 3'b111;
    repeat (3) begin run(); chk(gnt == 3'b100, "R7 lock hold", gnt, 3'b100); end
    stb = 3'b100; run(); chk(s_stb && gnt == 3'b100, "R4 owner strobe", {s_stb, gnt}, 4'b1100);
    stb = 3'b000; run(); chk(s_cyc && !s_stb, "R4 cyc without stb", {s_cyc, s_stb}, 2'b10);
    // R8: unlock, preempted between cycles
    lock = '0; run();
    chk(gnt == 3'b001, "R8 preempt", gnt, 3'b001);

    // R9: pending strobe holds the grant
    cyc = '0; run();
    chk(gnt == '0, "R11 no grant", gnt, 0);
    cyc = 3'b100; stb = 3'b100; run();
    cyc = 3'b101;
    repeat (2) begin run(); chk(gnt == 3'b100, "R9 pending hold", gnt, 3'b100); end
    s_ack = 1; #1;
    chk(ack == 3'b100, "R6 ack to owner", ack, 3'b100);
    run();
    chk(gnt == 3'b001 && ack == 3'b000, "R9 release after ack", {gnt, ack}, {3'b001, 3'b000});
    s_ack = 0;

    // R10: lock ignored once cycle drops
    cyc = 3'b010; lock = 3'b010; stb = 0; run();
    cyc = 3'b000; run();
    cyc = 3'b010; run();
    chk(gnt == 3'b010, "R10 locked owner", gnt, 3'b010);
    cyc = 3'b001; #1;
    chk(gnt == 3'b000, "R2 drop same cycle", gnt, 0);
    run();
    chk(gnt == 3'b001, "R10 lock ignored", gnt, 3'b001);
    lock = 3'b110; stb = 3'b110; s_err = 1; s_rty = 1; #1;
    chk((ack | err | rty) == '0, "R6 ungranted masters", {ack, err, rty}, 0);
    s_err = 0; s_rty = 0;

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      fields();
      for (int i = 0; i < N; i++) begin
        if ($urandom_range(0, 3) == 0) cyc[i] = ~cyc[i];
        stb[i]  = cyc[i] & ($urandom_range(0, 1) == 1);
        lock[i] = ($urandom_range(0, 3) == 0);
      end
      s_ack = ($urandom_range(0, 2) == 0);
      s_err = ($urandom_range(0, 9) == 0);
      s_rty = ($urandom_range(0, 9) == 0);
      run();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule